// File: doc/BRIEF.md
# Two-Mode VGA Raster Timing Generator

This block produces the raster timing for an analog VGA output. It runs on the pixel clock and drives five things: a horizontal sync, a vertical sync, a display-enable strobe, and the column and row of the pixel currently being shown. A one-bit mode input chooses between two fixed 60 Hz timing sets. Value 0 selects 640x480 and value 1 selects 1280x960. Each set has its own porch, sync and border widths and its own sync polarity.

Each line is split into six spans: the active span, then a trailing border, a front porch, the sync pulse, a back porch and a leading border. A frame is split into the same six spans, counted in lines. Borders count as blanked time. Every span width and both polarities are parameters, one set per mode, and their defaults are the stated figures. All outputs come straight from flops. A new mode is picked up only at a frame boundary.

Top module: `vga_timing_gen`

## Requirements
- R1: While reset is high, de, x and y are 0, and hsync and vsync sit at the inactive level of the mode that mode_sel currently selects. The raster position is line 0, pixel 0.
- R2: In mode 0 a line lasts 800 clocks: 640 active, 8 trailing border, 8 front porch, 96 sync, 40 back porch and 8 leading border. hsync is asserted from pixel 656 through pixel 751.
- R3: In mode 0 a frame lasts 525 lines: 480 active, 8 bottom border, 2 front porch, 2 sync, 25 back porch and 8 top border. vsync is asserted for the whole of lines 490 and 491.
- R4: In mode 1 a line lasts 1800 clocks: 1280 active, 96 front porch, 112 sync and 312 back porch, with no borders. hsync is asserted from pixel 1376 through pixel 1487.
- R5: In mode 1 a frame lasts 1000 lines: 960 active, 1 front porch, 3 sync and 36 back porch, with no borders. vsync is asserted for lines 961 through 963.
- R6: In mode 0 both syncs are active-low. In mode 1 both syncs are active-high.
- R7: de is 1 only for pixels inside the active span of a line that is itself inside the active span of the frame. It is 0 in every border, porch and sync span.
- R8: While de is 1, x and y equal the current pixel and line number. While de is 0, both are 0.
- R9: mode_sel is sampled only on the last clock of a frame. A change at any other time has no effect until the next frame begins, so no frame mixes the two timing sets.
- R10: Outputs are registered. The values seen after clock edge n describe raster position n-1 counted from reset release, so the first edge after reset shows pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | Timing set: 0 = 640x480, 1 = 1280x960 |
| hsync | output | 1 | Horizontal sync, polarity set by mode |
| vsync | output | 1 | Vertical sync, polarity set by mode |
| de | output | 1 | High during visible pixels |
| x | output | H_W | Pixel column while de is high, else 0 |
| y | output | V_W | Line number while de is high, else 0 |

## Verification
Every output sits one register stage behind the raster position. The value seen after edge n therefore belongs to the position the counters held before that edge. The bench model works out its expected value at the same edge and compares it at the following falling edge.

A mode_sel change is sampled on the last clock of a frame and shows up in the polarity and span widths of the very next output. The first clock of the new frame already uses the new timing set.

The reset levels are sampled while reset is still held. The first active pixel is expected exactly one edge after release.

Line lengths are measured from one sync assertion to the next, so they do not depend on any single edge.

// File: rtl/vga_tim_pkg.sv
package vga_tim_pkg;

    localparam int TW = 12;

    typedef enum logic {
        MODE_LO = 1'b0,
        MODE_HI = 1'b1
    } mode_e;

    typedef struct packed {
        logic [TW-1:0] act;
        logic [TW-1:0] tail_brd;
        logic [TW-1:0] fp;
        logic [TW-1:0] sw;
        logic [TW-1:0] bp;
        logic [TW-1:0] lead_brd;
        logic          pol;
    } axis_t;

    localparam axis_t H_LO_DEF = '{act: 12'd640, tail_brd: 12'd8, fp: 12'd8,
                                   sw: 12'd96, bp: 12'd40, lead_brd: 12'd8, pol: 1'b0};
    localparam axis_t V_LO_DEF = '{act: 12'd480, tail_brd: 12'd8, fp: 12'd2,
                                   sw: 12'd2, bp: 12'd25, lead_brd: 12'd8, pol: 1'b0};
    localparam axis_t H_HI_DEF = '{act: 12'd1280, tail_brd: 12'd0, fp: 12'd96,
                                   sw: 12'd112, bp: 12'd312, lead_brd: 12'd0, pol: 1'b1};
    localparam axis_t V_HI_DEF = '{act: 12'd960, tail_brd: 12'd0, fp: 12'd1,
                                   sw: 12'd3, bp: 12'd36, lead_brd: 12'd0, pol: 1'b1};

    function automatic logic [TW-1:0] ax_total(axis_t a);
        return a.act + a.tail_brd + a.fp + a.sw + a.bp + a.lead_brd;
    endfunction

    function automatic logic [TW-1:0] ax_sync_lo(axis_t a);
        return a.act + a.tail_brd + a.fp;
    endfunction

    function automatic logic [TW-1:0] ax_sync_hi(axis_t a);
        return a.act + a.tail_brd + a.fp + a.sw;
    endfunction

endpackage

// File: rtl/vga_axis_cnt.sv
module vga_axis_cnt #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] last,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    assign wrap = step && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/vga_axis_decode.sv
module vga_axis_decode
    import vga_tim_pkg::*;
#(
    parameter int W = 11
) (
    input  logic [W-1:0] cnt,
    input  axis_t        cfg,
    output logic         active,
    output logic         sync_lvl
);
    logic [TW-1:0] c;
    logic          in_sync;

    assign c        = TW'(cnt);
    assign active   = (c < cfg.act);
    assign in_sync  = (c >= ax_sync_lo(cfg)) && (c < ax_sync_hi(cfg));
    assign sync_lvl = cfg.pol ? in_sync : ~in_sync;
endmodule

// File: rtl/vga_mode_ctl.sv
module vga_mode_ctl
    import vga_tim_pkg::*;
#(
    parameter axis_t M0_H = H_LO_DEF,
    parameter axis_t M0_V = V_LO_DEF,
    parameter axis_t M1_H = H_HI_DEF,
    parameter axis_t M1_V = V_HI_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  mode_sel,
    input  logic  frame_end,
    output mode_e cur_mode,
    output axis_t h_cfg,
    output axis_t v_cfg,
    output logic  idle_h,
    output logic  idle_v
);
    always_ff @(posedge clk) begin
        if (rst || frame_end) begin
            cur_mode <= mode_e'(mode_sel);
        end
    end

    assign h_cfg  = (cur_mode == MODE_HI) ? M1_H : M0_H;
    assign v_cfg  = (cur_mode == MODE_HI) ? M1_V : M0_V;
    assign idle_h = mode_sel ? ~M1_H.pol : ~M0_H.pol;
    assign idle_v = mode_sel ? ~M1_V.pol : ~M0_V.pol;
endmodule

// File: rtl/vga_timing_gen.sv
module vga_timing_gen
    import vga_tim_pkg::*;
#(
    parameter int    H_W  = 11,
    parameter int    V_W  = 10,
    parameter axis_t M0_H = H_LO_DEF,
    parameter axis_t M0_V = V_LO_DEF,
    parameter axis_t M1_H = H_HI_DEF,
    parameter axis_t M1_V = V_HI_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mode_sel,
    output logic           hsync,
    output logic           vsync,
    output logic           de,
    output logic [H_W-1:0] x,
    output logic [V_W-1:0] y
);
    mode_e          cur_mode;
    axis_t          h_cfg, v_cfg;
    logic           idle_h, idle_v;
    logic [H_W-1:0] h_cnt, h_last;
    logic [V_W-1:0] v_cnt, v_last;
    logic           h_wrap, v_wrap;
    logic           h_act, v_act, h_lvl, v_lvl;

    assign h_last = H_W'(ax_total(h_cfg) - 1'b1);
    assign v_last = V_W'(ax_total(v_cfg) - 1'b1);

    vga_mode_ctl #(.M0_H(M0_H), .M0_V(M0_V), .M1_H(M1_H), .M1_V(M1_V)) u_mode (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .frame_end(v_wrap),
        .cur_mode(cur_mode), .h_cfg(h_cfg), .v_cfg(v_cfg),
        .idle_h(idle_h), .idle_v(idle_v)
    );

    vga_axis_cnt #(.W(H_W)) u_hcnt (
        .clk(clk), .rst(rst), .step(1'b1), .last(h_last), .cnt(h_cnt), .wrap(h_wrap)
    );

    vga_axis_cnt #(.W(V_W)) u_vcnt (
        .clk(clk), .rst(rst), .step(h_wrap), .last(v_last), .cnt(v_cnt), .wrap(v_wrap)
    );

    vga_axis_decode #(.W(H_W)) u_hdec (
        .cnt(h_cnt), .cfg(h_cfg), .active(h_act), .sync_lvl(h_lvl)
    );

    vga_axis_decode #(.W(V_W)) u_vdec (
        .cnt(v_cnt), .cfg(v_cfg), .active(v_act), .sync_lvl(v_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            de    <= 1'b0;
            x     <= '0;
            y     <= '0;
            hsync <= idle_h;
            vsync <= idle_v;
        end else begin
            de    <= h_act && v_act;
            x     <= (h_act && v_act) ? h_cnt : '0;
            y     <= (h_act && v_act) ? v_cnt : '0;
            hsync <= h_lvl;
            vsync <= v_lvl;
        end
    end
endmodule

// File: rtl/vga_timing_gen_chk.sv
module vga_timing_gen_chk #(
    parameter int H_W = 11,
    parameter int V_W = 10
) (
    input logic           clk,
    input logic           rst,
    input logic           de,
    input logic           hsync,
    input logic           vsync,
    input logic [H_W-1:0] x,
    input logic [V_W-1:0] y,
    input logic           cur_mode,
    input logic [H_W-1:0] h_cnt,
    input logic [H_W-1:0] h_last,
    input logic [V_W-1:0] v_cnt
);
    a_r8_xy_zero_when_blank: assert property (@(posedge clk) disable iff (rst)
        !de |-> (x == '0 && y == '0));

    a_r8_de_opens_at_col0: assert property (@(posedge clk) disable iff (rst)
        $rose(de) |-> (x == '0));

    a_r10_hcnt_steps: assert property (@(posedge clk) disable iff (rst)
        (h_cnt != h_last) |=> (h_cnt == $past(h_cnt) + 1'b1));

    a_r10_hcnt_wraps: assert property (@(posedge clk) disable iff (rst)
        (h_cnt == h_last) |=> (h_cnt == '0));

    a_r3_vcnt_moves_at_line_start: assert property (@(posedge clk) disable iff (rst)
        (h_cnt != '0) |-> $stable(v_cnt));

    a_r9_mode_held_in_frame: assert property (@(posedge clk) disable iff (rst)
        (h_cnt != '0 || v_cnt != '0) |-> $stable(cur_mode));

    a_r7_syncs_quiet_in_active: assert property (@(posedge clk) disable iff (rst)
        (de && $past(de)) |-> ($stable(hsync) && $stable(vsync)));
endmodule

bind vga_timing_gen vga_timing_gen_chk #(.H_W(H_W), .V_W(V_W)) u_chk (
    .clk(clk), .rst(rst), .de(de), .hsync(hsync), .vsync(vsync),
    .x(x), .y(y), .cur_mode(cur_mode), .h_cnt(h_cnt), .h_last(h_last), .v_cnt(v_cnt)
);

// File: tb/vga_timing_gen_bench.sv
module vga_timing_gen_bench;
    import vga_tim_pkg::*;

    // Reduced timing sets keep whole frames inside the run budget.
    localparam axis_t T0H = '{act: 12'd16, tail_brd: 12'd2, fp: 12'd2, sw: 12'd4, bp: 12'd3, lead_brd: 12'd2, pol: 1'b0};
    localparam axis_t T0V = '{act: 12'd6, tail_brd: 12'd1, fp: 12'd1, sw: 12'd1, bp: 12'd2, lead_brd: 12'd1, pol: 1'b0};
    localparam axis_t T1H = '{act: 12'd20, tail_brd: 12'd0, fp: 12'd3, sw: 12'd5, bp: 12'd4, lead_brd: 12'd0, pol: 1'b1};
    localparam axis_t T1V = '{act: 12'd5, tail_brd: 12'd0, fp: 12'd1, sw: 12'd2, bp: 12'd3, lead_brd: 12'd0, pol: 1'b1};

    localparam int H_ACT[2] = '{16, 20};
    localparam int H_SS[2]  = '{20, 23};
    localparam int H_SW[2]  = '{4, 5};
    localparam int H_TOT[2] = '{29, 32};
    localparam int V_ACT[2] = '{6, 5};
    localparam int V_SS[2]  = '{8, 6};
    localparam int V_SW[2]  = '{1, 2};
    localparam int V_TOT[2] = '{12, 11};
    localparam int POL[2]   = '{0, 1};

    // Stimulus table: {mode_sel value, clocks to hold it}
    localparam int NSEG = 6;
    localparam int SEG[NSEG][2] = '{'{0, 400}, '{1, 200}, '{1, 500}, '{0, 360}, '{1, 700}, '{0, 100}};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_sel = 1'b0;
    logic        hsync, vsync, de;
    logic [10:0] x;
    logic [9:0]  y;

    always #10 clk = ~clk;

    vga_timing_gen #(.H_W(11), .V_W(10), .M0_H(T0H), .M0_V(T0V), .M1_H(T1H), .M1_V(T1V)) u_vga_timing_gen (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .hsync(hsync), .vsync(vsync), .de(de), .x(x), .y(y)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference raster model
    int px = 0, ln = 0, mm = 0, e_m = 0;
    int e_de = 0, e_x = 0, e_y = 0, e_hs = 1, e_vs = 1;
    always @(posedge clk) begin
        if (rst) begin
            px = 0; ln = 0; mm = int'(mode_sel); e_m = mm;
            e_de = 0; e_x = 0; e_y = 0;
            e_hs = 1 - POL[mm]; e_vs = 1 - POL[mm];
        end else begin
            bit hon, von;
            e_m  = mm;
            e_de = (px < H_ACT[mm] && ln < V_ACT[mm]) ? 1 : 0;
            e_x  = e_de ? px : 0;
            e_y  = e_de ? ln : 0;
            hon  = (px >= H_SS[mm]) && (px < H_SS[mm] + H_SW[mm]);
            von  = (ln >= V_SS[mm]) && (ln < V_SS[mm] + V_SW[mm]);
            e_hs = POL[mm] ? int'(hon) : int'(!hon);
            e_vs = POL[mm] ? int'(von) : int'(!von);
            if (px == H_TOT[mm] - 1) begin
                px = 0;
                if (ln == V_TOT[mm] - 1) begin
                    ln = 0;
                    mm = int'(mode_sel);
                end else begin
                    ln++;
                end
            end else begin
                px++;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R7 de", int'(de), e_de);
            check("R8 x", int'(x), e_x);
            check("R8 y", int'(y), e_y);
            check(e_m ? "R4 R6 hsync" : "R2 R6 hsync", int'(hsync), e_hs);
            check(e_m ? "R5 R6 vsync" : "R3 R6 vsync", int'(vsync), e_vs);
        end
    end

    task automatic hs_period(input logic pol, output int per);
        int c;
        @(negedge clk);
        while (hsync != pol) @(negedge clk);
        while (hsync == pol) @(negedge clk);
        while (hsync != pol) @(negedge clk);
        c = 0;
        while (hsync == pol) begin c++; @(negedge clk); end
        while (hsync != pol) begin c++; @(negedge clk); end
        per = c;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++;
            n_err++;
            $display("FAIL R10 watchdog actual=%0d expected<=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        int per;
        // R1: reset levels, mode 0 idle is high
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 de in reset", int'(de), 0);
        check("R1 x in reset", int'(x), 0);
        check("R1 y in reset", int'(y), 0);
        check("R1 R6 hsync idle mode0", int'(hsync), 1);
        check("R1 R6 vsync idle mode0", int'(vsync), 1);
        // R1: mode 1 idle is low
        mode_sel = 1'b1;
        @(negedge clk);
        check("R1 R6 hsync idle mode1", int'(hsync), 0);
        check("R1 R6 vsync idle mode1", int'(vsync), 0);
        mode_sel = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        // R10: first edge after release shows pixel 0 of line 0
        @(negedge clk);
        check("R10 first de", int'(de), 1);
        check("R10 first x", int'(x), 0);
        check("R10 first y", int'(y), 0);

        // Table walk, checked continuously by the model
        for (int i = 0; i < NSEG; i++) begin
            mode_sel = SEG[i][0][0];
            repeat (SEG[i][1]) @(negedge clk);
        end

        // R9: mid-frame change must not alter the current frame
        rst = 1'b1; mode_sel = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        mode_sel = 1'b1;
        hs_period(1'b0, per);
        check("R9 R2 line length kept mid-frame", per, H_TOT[0]);
        repeat (400) @(negedge clk);
        hs_period(1'b1, per);
        check("R9 R4 line length after frame end", per, H_TOT[1]);
        mode_sel = 1'b0;
        repeat (400) @(negedge clk);
        hs_period(1'b0, per);
        check("R9 R2 line length back in mode0", per, H_TOT[0]);

        finish_run();
    end
endmodule